// File: doc/BRIEF.md
# Bridge Interrupt Message Aggregator

This block gathers eleven interrupt request lines from a bus bridge and reports them to a host processor through a single shared path. Whenever an enabled line changes level, the block latches that change in a pending register and issues one posted message write. The message carries a 32-bit word taken from a software-programmed target register, which holds the target address and the data value merged into one word.

Software sees five word registers. Two of them are views of the pending state, and either one clears that state when it is read. One is the enable mask. One shows the live synchronised level of every line. One is the message target word. Lines 0 to 5 are the six shared PCI interrupt pins A to F. Line 6 is an external bus interrupt and line 10 is an on-chip serial port. Lines 8 and 9 carry nothing, and line 9 is not implemented in the pending state. A line that is already high when software unmasks it does not start a message. The block instead gives a one-cycle re-trigger pulse, and software can then compare the level view against the mask.

Top module: `irq_msg_aggregator`

## Requirements
- R1: After reset the pending state, mask and target word read as zero and `msg_valid` is low.
- R2: Register index 3 returns the level of all eleven inputs, after a two-flop synchroniser, in bits 10:0. A level change on an input shows there two clock edges after it is applied.
- R3: A change in either direction on an input whose mask bit is 1 sets its pending bit. A change on a masked input sets nothing. The mask register is index 2, and bit n of it enables line n.
- R4: Pending bits exist only where the implemented set 0x5FF has a 1. Line 9 never shows as pending.
- R5: A read of index 0 or index 1 returns the pending bits in 10:0 and clears them in the same access. The level view is unchanged by that read.
- R6: A change that is captured in the same cycle as a clearing read is not lost. It appears at the next read.
- R7: A captured change on an enabled line raises `msg_valid`, with `msg_word` equal to the target register (index 4) at the moment of launch.
- R8: While `msg_valid` is high and `msg_ready` is low, the valid signal and the word hold steady. Any number of changes during that wait cause exactly one further message once the first one is accepted. That message carries the target word current at its launch.
- R9: A mask write that enables a line which is already high gives `retrig_pulse` for exactly one cycle, and it raises no message and no pending bit. Enabling a line that is low gives no pulse.
- R10: Writes to indices 0, 1 and 3 are ignored. Unused indices read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 11 | Raw interrupt request lines |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read-clear) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_word | output | 32 | Merged target address and data word of the message |
| retrig_pulse | output | 1 | One-cycle flag: a line was high when it was unmasked |

## Verification
The bench sweeps every line in both directions under three mask patterns. This exposes a design that ignores falling edges, lets masked or unimplemented line 9 set pending state, or mixes up bit positions. It arranges a line change to land in exactly the cycle of a clearing read; a design that clears after merging would drop that change. It holds a message unaccepted while further changes arrive and the target word is rewritten. A design that drops the deferred message, sends two, or lets the word move under a waiting request is caught. It also unmasks lines that are high and lines that are low. A design that sends a message instead of the re-trigger pulse, or pulses for a quiet line, fails.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    IDX_PEND     = 3'd0,
    IDX_PEND_ALT = 3'd1,
    IDX_MASK     = 3'd2,
    IDX_LEVEL    = 3'd3,
    IDX_TARGET   = 3'd4
  } reg_idx_t;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irqagg_capture.sv
module irqagg_capture #(
  parameter int           W    = 11,
  parameter logic [W-1:0] IMPL = 11'h5FF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] enable,
  input  logic         clear,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] change_en
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_d;

  // Either edge counts; only enabled, implemented lines are kept.
  always_comb begin
    change_en = (level ^ prev_q) & enable & IMPL;
    pend_d    = (clear ? '0 : pend_q) | change_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= level;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irqagg_msg.sv
module irqagg_msg #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WORD_W-1:0] target,
  input  logic              ready,
  output logic              valid_q,
  output logic [WORD_W-1:0] word_q
);
  logic busy;
  logic defer_q;
  logic valid_d;
  logic defer_d;
  logic load_en;

  always_comb begin
    busy    = valid_q & ~ready;
    valid_d = busy | launch | defer_q;
    defer_d = busy & (launch | defer_q);
    load_en = ~busy & (launch | defer_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      defer_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_d;
      defer_q <= defer_d;
      if (load_en) word_q <= target;
    end
  end
endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator
  import irqagg_pkg::*;
#(
  parameter int                 N_LINES     = 11,
  parameter logic [N_LINES-1:0] IMPL        = 11'h5FF,
  parameter int                 WORD_W      = 32,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [WORD_W-1:0]  msg_word,
  output logic               retrig_pulse
);
  localparam int PAD_W = WORD_W - N_LINES;

  logic [1:0]         rs_q;
  logic               rst_n_int;
  logic [N_LINES-1:0] level;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] mask_d;
  logic [WORD_W-1:0]  target_q;
  logic [WORD_W-1:0]  target_d;
  logic               retrig_q;
  logic               retrig_d;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] change_en;
  logic               pend_clear;
  logic               mask_we;
  logic               target_we;
  reg_idx_t           idx;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_int = rs_q[1];

  irqagg_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in (irq_in),
    .sync_out (level)
  );

  irqagg_capture #(.W(N_LINES), .IMPL(IMPL)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .level     (level),
    .enable    (mask_q),
    .clear     (pend_clear),
    .pend_q    (pend_q),
    .change_en (change_en)
  );

  irqagg_msg #(.WORD_W(WORD_W)) u_msg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .launch  (|change_en),
    .target  (target_q),
    .ready   (msg_ready),
    .valid_q (msg_valid),
    .word_q  (msg_word)
  );

  always_comb begin
    idx        = reg_idx_t'(reg_addr);
    pend_clear = reg_rd & ((idx == IDX_PEND) | (idx == IDX_PEND_ALT));
    mask_we    = reg_wr & (idx == IDX_MASK);
    target_we  = reg_wr & (idx == IDX_TARGET);
    mask_d     = reg_wdata[N_LINES-1:0];
    target_d   = reg_wdata;
    retrig_d   = mask_we & |(mask_d & ~mask_q & level);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mask_q   <= '0;
      target_q <= '0;
      retrig_q <= 1'b0;
    end else begin
      if (mask_we)   mask_q   <= mask_d;
      if (target_we) target_q <= target_d;
      retrig_q <= retrig_d;
    end
  end

  assign retrig_pulse = retrig_q;

  always_comb begin
    case (idx)
      IDX_PEND, IDX_PEND_ALT: reg_rdata = {{PAD_W{1'b0}}, pend_q};
      IDX_MASK:               reg_rdata = {{PAD_W{1'b0}}, mask_q};
      IDX_LEVEL:              reg_rdata = {{PAD_W{1'b0}}, level};
      IDX_TARGET:             reg_rdata = target_q;
      default:                reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_msg_aggregator_chk.sv
module irq_msg_aggregator_chk #(
  parameter int                 N_LINES = 11,
  parameter logic [N_LINES-1:0] IMPL    = 11'h5FF,
  parameter int                 WORD_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_rd,
  input logic [2:0]         reg_addr,
  input logic [WORD_W-1:0]  reg_rdata,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [WORD_W-1:0]  msg_word,
  input logic               retrig_pulse,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] change_en
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid); // R8
  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> $stable(msg_word)); // R8
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> ((reg_rdata[N_LINES-1:0] & ~IMPL) == '0)); // R4
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == 3'd0 || reg_addr == 3'd1) && change_en == '0) |=> (pend == '0)); // R5
  AST_RETRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    retrig_pulse |=> !retrig_pulse); // R9
endmodule

bind irq_msg_aggregator irq_msg_aggregator_chk #(
  .N_LINES(N_LINES), .IMPL(IMPL), .WORD_W(WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_int),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .msg_valid    (msg_valid),
  .msg_ready    (msg_ready),
  .msg_word     (msg_word),
  .retrig_pulse (retrig_pulse),
  .pend         (pend_q),
  .change_en    (change_en)
);

// File: tb/test_irq_msg_aggregator.sv
module test_irq_msg_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam logic [10:0] IMPL = 11'h5FF;

  logic        clk;
  logic        rst_n;
  logic [10:0] irq_in;
  logic [2:0]  reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        msg_valid;
  logic        msg_ready;
  logic [31:0] msg_word;
  logic        retrig_pulse;

  int n_chk = 0;
  int n_bad = 0;
  logic last_retrig;

  irq_msg_aggregator i_irq_msg_aggregator (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_word(msg_word),
    .retrig_pulse(retrig_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    last_retrig = retrig_pulse;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [10:0] masks [3];
    masks[0] = 11'h7FF; masks[1] = 11'h000; masks[2] = 11'h2A5;
    rst_n = 1'b0; irq_in = '0; reg_addr = '0; reg_wr = 0; reg_rd = 0;
    reg_wdata = '0; msg_ready = 0; last_retrig = 0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(4);

    // R1 reset state
    reg_read(3'd0, rd); check("R1 pending", rd, 32'h0);
    reg_read(3'd2, rd); check("R1 mask", rd, 32'h0);
    reg_read(3'd4, rd); check("R1 target", rd, 32'h0);
    check("R1 msg_valid", {31'b0, msg_valid}, 32'h0);

    // R2 R3 R4 R5 R7 sweep: every line, both edges, three masks
    for (int m = 0; m < 3; m++) begin
      reg_write(3'd2, {21'b0, masks[m]});
      for (int b = 0; b < 11; b++) begin
        logic [31:0] tgt;
        logic [10:0] exp;
        logic [2:0]  pidx;
        tgt  = 32'hC000_0000 | (m << 12) | (b << 4) | 32'h3;
        exp  = (11'(1) << b) & masks[m] & IMPL;
        pidx = (b % 2 == 0) ? 3'd0 : 3'd1;
        reg_write(3'd4, tgt);
        for (int e = 0; e < 2; e++) begin
          irq_in[b] = ~irq_in[b];
          wait_neg(4);
          reg_read(3'd3, rd); check("R2 level", rd, {21'b0, irq_in});
          check("R7 valid", {31'b0, msg_valid}, {31'b0, (exp != 0)});
          if (exp != 0) check("R7 word", msg_word, tgt);
          if (msg_valid) accept();
          check("R7 valid after accept", {31'b0, msg_valid}, 32'h0);
          reg_read(pidx, rd); check("R3 R4 pending", rd, {21'b0, exp});
          reg_read(3'd3, rd); check("R5 level kept", rd, {21'b0, irq_in});
          reg_read(pidx, rd); check("R5 cleared", rd, 32'h0);
        end
      end
    end

    // R8 deferred message and word stability
    reg_write(3'd2, 32'h7FF);
    reg_write(3'd4, 32'h1111_0001);
    irq_in[0] = 1'b1;
    wait_neg(4);
    check("R8 first valid", {31'b0, msg_valid}, 32'h1);
    reg_write(3'd4, 32'h2222_0002);
    irq_in[1] = 1'b1;
    wait_neg(2);
    irq_in[2] = 1'b1;
    wait_neg(4);
    check("R8 held valid", {31'b0, msg_valid}, 32'h1);
    check("R8 held word", msg_word, 32'h1111_0001);
    accept();
    check("R8 second valid", {31'b0, msg_valid}, 32'h1);
    check("R8 second word", msg_word, 32'h2222_0002);
    accept();
    check("R8 no third", {31'b0, msg_valid}, 32'h0);
    reg_read(3'd0, rd); check("R8 pending merged", rd, 32'h7);
    irq_in[2:0] = 3'b000;
    wait_neg(4);
    accept();
    reg_read(3'd0, rd); check("R3 falling merged", rd, 32'h7);

    // R6 change lands in the clearing-read cycle
    irq_in[5] = 1'b1;
    wait_neg(4);
    accept();
    @(negedge clk);
    irq_in[4] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_addr = 3'd0; reg_rd = 1'b1;
    #1 rd = reg_rdata;
    check("R6 read before merge", rd, 32'h20);
    @(negedge clk);
    reg_rd = 1'b0;
    reg_read(3'd0, rd); check("R6 change kept", rd, 32'h10);
    accept();
    irq_in = '0;
    wait_neg(4);
    accept();
    reg_read(3'd0, rd);

    // R9 unmask an already-high line
    reg_write(3'd2, 32'h0);
    irq_in[3] = 1'b1;
    wait_neg(4);
    reg_read(3'd0, rd);
    reg_write(3'd2, 32'h008);
    check("R9 pulse", {31'b0, last_retrig}, 32'h1);
    wait_neg(1);
    check("R9 pulse one cycle", {31'b0, retrig_pulse}, 32'h0);
    wait_neg(3);
    check("R9 no message", {31'b0, msg_valid}, 32'h0);
    reg_read(3'd0, rd); check("R9 no pending", rd, 32'h0);
    reg_write(3'd2, 32'h018);
    check("R9 low line no pulse", {31'b0, last_retrig}, 32'h0);
    reg_read(3'd3, rd);
    check("R9 level and mask", rd & 32'h018, 32'h008);

    // R10 ignored writes, unused index
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_write(3'd1, 32'hFFFF_FFFF);
    reg_write(3'd3, 32'h0);
    reg_read(3'd0, rd); check("R10 pending write ignored", rd, 32'h0);
    reg_read(3'd3, rd); check("R10 level write ignored", rd, 32'h008);
    reg_read(3'd6, rd); check("R10 unused index", rd, 32'h0);
    check("R10 no message", {31'b0, msg_valid}, 32'h0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule